// File: doc/BRIEF.md
# Incremental Conductance Maximum Power Point Stepper

This block performs one iteration of an incremental-conductance search for the maximum power point of a solar panel. Each accepted sample carries an unsigned panel voltage and an unsigned panel current. The block differences the sample against the one it accepted before. It then moves a boost-converter duty command up by the step size, down by the step size, or leaves it where it is. The new duty value is announced with a one-cycle done pulse.

The block compares the incremental conductance dI/dV against the negative instantaneous conductance -I/V without a divider. Both sides are multiplied by V·dV. The test then reduces to the sign of S = dI·V + I·dV, read against the sign of dV. The duty command is clamped between two parameter limits.

Samples enter through a valid/ready pair. `smp_ready` drops for the single cycle in which an accepted sample is being evaluated. An upstream source must therefore hold `smp_valid` and its data until it sees ready high at a clock edge. The done pulse has no back-pressure. `duty_o` keeps its value until the next update.

Top module: `mppt_incond_stepper`

## Requirements
- R1: After reset, `duty_o` equals DUTY_RST (default 2048), `upd_done` is low and `smp_ready` is high.
- R2: The first sample accepted after reset only becomes the stored reference. It still raises `upd_done`, and `duty_o` keeps its value.
- R3: When dV = 0 and dI = 0, the duty is unchanged.
- R4: When dV = 0, a positive dI raises the duty by `step_i` and a negative dI lowers it by `step_i`.
- R5: When dV ≠ 0 and dI·V = -I·dV, the duty is unchanged.
- R6: When dV ≠ 0, the duty rises by `step_i` if S = dI·V + I·dV and dV have the same sign. It falls by `step_i` if their signs differ. This covers both signs of dV.
- R7: The duty never exceeds DUTY_MAX (default 3686) and never falls below DUTY_MIN (default 410). A step that would pass a limit lands exactly on that limit.
- R8: Every accepted sample becomes the reference for the next difference, including samples that cause no change.
- R9: A sample is taken only at an edge where `smp_valid` and `smp_ready` are both high. `smp_ready` is low in the following cycle. `upd_done` is high for exactly one cycle, starting two edges after the accepting edge.
- R10: `duty_o` changes only in a cycle where `upd_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | A voltage/current sample is offered |
| smp_ready | output | 1 | The block can take a sample at this edge |
| volt_i | input | VW | Unsigned panel voltage |
| curr_i | input | IW | Unsigned panel current |
| step_i | input | SW | Duty increment, captured with the sample |
| duty_o | output | DW | Duty command for the boost converter |
| upd_done | output | 1 | One-cycle pulse: `duty_o` holds the result of a new sample |

## Verification
The assertions assume three things about the inputs. First, the voltage of an accepted sample is nonzero. Second, `step_i` is nonzero. Third, once reset is released, `smp_valid` is never unknown.

The stimulus keeps every voltage well above zero. It uses step sizes of 100 and 4000 only. It drives `smp_valid` low or high from time zero.

Voltage and current pairs are chosen so that the sign of S lands on each branch for both signs of dV, including an exact equality. The large step drives the duty into each limit. A repeated sample shows that the reference was refreshed.

// File: rtl/mppt_pkg.sv
package mppt_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } dir_e;
endpackage

// File: rtl/mppt_delta.sv
module mppt_delta #(
  parameter int VW = 12,
  parameter int IW = 12,
  parameter int SW = 12,
  localparam int PW = VW + IW + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic [VW-1:0]        volt,
  input  logic [IW-1:0]        curr,
  input  logic [SW-1:0]        step,
  output logic                 s1_vld,
  output logic                 s1_first,
  output logic signed [VW:0]   s1_dv,
  output logic signed [IW:0]   s1_di,
  output logic signed [PW-1:0] s1_sum,
  output logic [SW-1:0]        s1_step
);
  logic [VW-1:0] v_ref;
  logic [IW-1:0] i_ref;
  logic          primed;

  logic signed [VW:0]   dv_c;
  logic signed [IW:0]   di_c;
  logic signed [PW-1:0] sum_c;

  always_comb begin
    dv_c  = $signed({1'b0, volt}) - $signed({1'b0, v_ref});
    di_c  = $signed({1'b0, curr}) - $signed({1'b0, i_ref});
    // dI*V + I*dV : sign decides the conductance comparison
    sum_c = PW'(di_c) * PW'($signed({1'b0, volt}))
          + PW'(dv_c) * PW'($signed({1'b0, curr}));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_ref    <= '0;
      i_ref    <= '0;
      primed   <= 1'b0;
      s1_vld   <= 1'b0;
      s1_first <= 1'b0;
      s1_dv    <= '0;
      s1_di    <= '0;
      s1_sum   <= '0;
      s1_step  <= '0;
    end else begin
      s1_vld <= take;
      if (take) begin
        v_ref    <= volt;
        i_ref    <= curr;
        primed   <= 1'b1;
        s1_first <= !primed;
        s1_dv    <= dv_c;
        s1_di    <= di_c;
        s1_sum   <= sum_c;
        s1_step  <= step;
      end
    end
  end
endmodule

// File: rtl/mppt_decide.sv
module mppt_decide
  import mppt_pkg::*;
#(
  parameter int VW = 12,
  parameter int IW = 12,
  localparam int PW = VW + IW + 3
) (
  input  logic                 first,
  input  logic signed [VW:0]   dv,
  input  logic signed [IW:0]   di,
  input  logic signed [PW-1:0] sum,
  output dir_e                 dir
);
  logic dv_zero, dv_neg, sum_zero, sum_neg;

  always_comb begin
    dv_zero  = (dv == '0);
    dv_neg   = dv[VW];
    sum_zero = (sum == '0);
    sum_neg  = sum[PW-1];
    if (first) begin
      dir = DIR_HOLD;
    end else if (dv_zero) begin
      if (di == '0)   dir = DIR_HOLD;
      else if (di[IW]) dir = DIR_DOWN;
      else            dir = DIR_UP;
    end else if (sum_zero) begin
      dir = DIR_HOLD;
    end else if (sum_neg == dv_neg) begin
      dir = DIR_UP;
    end else begin
      dir = DIR_DOWN;
    end
  end
endmodule

// File: rtl/mppt_duty_acc.sv
module mppt_duty_acc
  import mppt_pkg::*;
#(
  parameter int DW       = 12,
  parameter int SW       = 12,
  parameter int DUTY_MIN = 410,
  parameter int DUTY_MAX = 3686,
  parameter int DUTY_RST = 2048,
  localparam int AW = ((DW > SW) ? DW : SW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apply,
  input  dir_e          dir,
  input  logic [SW-1:0] step,
  output logic [DW-1:0] duty,
  output logic          done
);
  logic [AW-1:0] cur_w, step_w, up_w, lo_w, hi_w;
  logic [DW-1:0] nxt;

  always_comb begin
    cur_w  = AW'(duty);
    step_w = AW'(step);
    up_w   = cur_w + step_w;
    lo_w   = AW'(DUTY_MIN);
    hi_w   = AW'(DUTY_MAX);
    nxt    = duty;
    case (dir)
      DIR_UP:   nxt = (up_w > hi_w) ? DW'(DUTY_MAX) : DW'(up_w);
      DIR_DOWN: nxt = (cur_w < lo_w + step_w) ? DW'(DUTY_MIN) : DW'(cur_w - step_w);
      default:  nxt = duty;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty <= DW'(DUTY_RST);
      done <= 1'b0;
    end else begin
      done <= apply;
      if (apply) duty <= nxt;
    end
  end

  // R7
  duty_in_limits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty >= DW'(DUTY_MIN)) && (duty <= DW'(DUTY_MAX)));

  // R4
  up_moves_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && dir == DIR_UP && step != '0 && duty < DW'(DUTY_MAX)) |=> (duty > $past(duty)));
endmodule

// File: rtl/mppt_incond_stepper.sv
module mppt_incond_stepper
  import mppt_pkg::*;
#(
  parameter int VW       = 12,
  parameter int IW       = 12,
  parameter int SW       = 12,
  parameter int DW       = 12,
  parameter int DUTY_MIN = 410,
  parameter int DUTY_MAX = 3686,
  parameter int DUTY_RST = 2048,
  localparam int PW = VW + IW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [VW-1:0] volt_i,
  input  logic [IW-1:0] curr_i,
  input  logic [SW-1:0] step_i,
  output logic [DW-1:0] duty_o,
  output logic          upd_done
);
  logic                 take;
  logic                 s1_vld, s1_first;
  logic signed [VW:0]   s1_dv;
  logic signed [IW:0]   s1_di;
  logic signed [PW-1:0] s1_sum;
  logic [SW-1:0]        s1_step;
  dir_e                 dir;

  assign smp_ready = !s1_vld;
  assign take      = smp_valid && smp_ready;

  mppt_delta #(.VW(VW), .IW(IW), .SW(SW)) u_delta (
    .clk(clk), .rst_n(rst_n), .take(take),
    .volt(volt_i), .curr(curr_i), .step(step_i),
    .s1_vld(s1_vld), .s1_first(s1_first), .s1_dv(s1_dv),
    .s1_di(s1_di), .s1_sum(s1_sum), .s1_step(s1_step)
  );

  mppt_decide #(.VW(VW), .IW(IW)) u_decide (
    .first(s1_first), .dv(s1_dv), .di(s1_di), .sum(s1_sum), .dir(dir)
  );

  mppt_duty_acc #(
    .DW(DW), .SW(SW), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX), .DUTY_RST(DUTY_RST)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .apply(s1_vld), .dir(dir),
    .step(s1_step), .duty(duty_o), .done(upd_done)
  );

  // R9
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !smp_ready);

  // R9
  done_follows_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ##1 upd_done);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !upd_done);

  // R10
  duty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_done |-> $stable(duty_o));
endmodule

// File: tb/tb_mppt_incond_stepper.sv
module tb_mppt_incond_stepper;
  localparam int DMIN = 410;
  localparam int DMAX = 3686;
  localparam int DRST = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [11:0] volt_i = '0;
  logic [11:0] curr_i = '0;
  logic [11:0] step_i = '0;
  logic [11:0] duty_o;
  logic        upd_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int    exp_q[$];
  string tag_q[$];

  int m_duty, m_vp, m_ip;
  bit m_primed;

  always #2 clk = ~clk;

  mppt_incond_stepper dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .volt_i(volt_i), .curr_i(curr_i), .step_i(step_i),
    .duty_o(duty_o), .upd_done(upd_done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model(input int v, input int i, input int st, input string tag);
    int dv, di, s, nd;
    nd = m_duty;
    if (m_primed) begin
      dv = v - m_vp;
      di = i - m_ip;
      s  = di * v + i * dv;
      if (dv == 0) begin
        if (di > 0) nd = m_duty + st;
        else if (di < 0) nd = m_duty - st;
      end else if (s != 0) begin
        if ((s > 0) == (dv > 0)) nd = m_duty + st;
        else nd = m_duty - st;
      end
      if (nd > DMAX) nd = DMAX;
      if (nd < DMIN) nd = DMIN;
    end
    m_primed = 1;
    m_vp = v;
    m_ip = i;
    m_duty = nd;
    exp_q.push_back(nd);
    tag_q.push_back(tag);
  endtask

  task automatic send(input int v, input int i, input int st, input string tag);
    model(v, i, st, tag);
    @(negedge clk);
    volt_i = 12'(v);
    curr_i = 12'(i);
    step_i = 12'(st);
    smp_valid = 1'b1;
    while (!smp_ready) @(negedge clk);
    @(negedge clk);
    check("R9 ready low after accept", int'(smp_ready), 0);
    smp_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_duty = DRST;
    m_primed = 0;
    repeat (3) @(negedge clk);
    check("R1 duty after reset", int'(duty_o), DRST);
    check("R1 done low in reset", int'(upd_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(smp_ready), 1);
    check("R1 duty idle", int'(duty_o), DRST);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && upd_done) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected done", 1, 0);
      end else begin
        check(tag_q.pop_front(), int'(duty_o), exp_q.pop_front());
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    send(1000, 500, 100, "R2 first sample primes only");
    send(1000, 500, 100, "R3 dV=0 dI=0 hold");
    send(1000, 600, 100, "R4 dV=0 dI>0 up");
    send(1000, 550, 100, "R4 dV=0 dI<0 down");
    send(1000, 600, 100, "R4 dV=0 dI>0 up again");
    send(2000, 400, 100, "R5 equality hold");
    send(2000, 400, 100, "R8 reference refreshed, hold");
    send(1500, 500, 100, "R6 dV<0 S<0 up");
    send(1400, 450, 100, "R6 dV<0 S<0 up");
    send(1300, 800, 100, "R6 dV<0 S>0 down");
    send(1400, 800, 100, "R6 dV>0 S>0 up");
    send(1500, 300, 100, "R6 dV>0 S<0 down");
    send(1500, 900, 4000, "R7 clamp at max");
    send(1500, 950, 4000, "R7 stay at max");
    send(1500, 100, 4000, "R7 clamp at min");
    send(1500, 50, 4000, "R7 stay at min");
    // R10: idle period leaves duty untouched
    repeat (5) @(negedge clk);
    check("R10 duty stable while idle", int'(duty_o), m_duty);
    do_reset();
    send(500, 200, 100, "R2 first sample after second reset");
    send(500, 300, 100, "R4 up after second reset");
    repeat (4) @(negedge clk);
    check("R9 all updates reported", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule